// File: doc/BRIEF.md
# Tiled-Region Fence Programmer

This block loads one of a set of detiling fence slots with a description of a tiled memory region. A request carries a slot index plus either a clear command or a region descriptor. The descriptor gives the start address, the region size in bytes, the row stride in bytes and the tiling mode. The block checks the descriptor and packs it into a 64-bit fence word. It then pushes that word onto a 32-bit register bus as a short, strictly ordered series of writes and read-backs.

The order exists so that the hardware that consumes the fence never sees a half-updated entry. The slot is first switched off and that write is confirmed. The upper half is written next. The lower half, which carries the enable bit, is written last and is confirmed with a final read-back. The block reports busy while it works and pulses done when the series ends. A descriptor that is malformed raises a one-cycle error pulse and causes no bus traffic.

Top module: `tfence_prog`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, err and bus_req are all 0.
- R2: Fence word for a region: lower half = start address with bit 0 (enable) set to 1 and bit 1 set to 1 for Y tiling (req_mode 2'b10) or 0 for X tiling (req_mode 2'b01). Upper half bits 31:12 = end address (start + size − 4096) bits 31:12.
- R3: Pitch field = stride/128 − 1, placed at bit PITCH_SHIFT of the 64-bit word (by default upper-half bits 9:0, PITCH_W = 10 bits).
- R4: Each accepted request produces exactly five bus operations in this order: write 0 to the low word, read the low word, write the upper half to the high word, write the lower half to the low word, read the low word.
- R5: The low word of slot s sits at BASE_ADDR + 8·s and the high word at BASE_ADDR + 8·s + 4 (BASE_ADDR = 0x4000 by default, 32 slots).
- R6: A clear request (req_clear = 1) writes an all-zero word through the same five-step series, whatever the descriptor fields hold.
- R7: A region request is rejected if any of these holds: start or size not a multiple of 4096, size zero, stride zero or not a multiple of 128, stride/128 > 2^PITCH_W, tiling mode 2'b00 or 2'b11, or end address above 0xFFFF_FFFF. A rejected request pulses err for one cycle, the cycle after the request, and starts no bus operation.
- R8: A request is taken only while busy is 0. A request raised while busy is ignored and causes no bus operation. Busy rises the cycle after a valid request is taken.
- R9: done is a single-cycle pulse in the cycle right after the acknowledge of the final read-back, and busy is 0 in that cycle.
- R10: Each bus operation keeps bus_req, bus_we, bus_addr and bus_wdata steady until bus_ack is seen. The next operation starts only after that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_clear | input | 1 | 1 = clear the slot, descriptor ignored |
| req_slot | input | 5 | Fence slot index |
| req_start | input | 32 | Region start address |
| req_size | input | 32 | Region size in bytes |
| req_stride | input | 32 | Row stride in bytes |
| req_mode | input | 2 | 01 = X tiling, 10 = Y tiling, 00/11 invalid |
| busy | output | 1 | A write series is in progress |
| done | output | 1 | One-cycle pulse when a series finishes |
| err | output | 1 | One-cycle pulse for a rejected request |
| bus_req | output | 1 | Bus operation pending |
| bus_we | output | 1 | 1 = write, 0 = read-back |
| bus_addr | output | 32 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Completes the pending operation |

## Verification
The assertions assume the bus side behaves like a register target. bus_ack is raised for one cycle and only while bus_req is high, and req_valid is a single-cycle strobe. The bench's bus model returns each acknowledge after a random wait of zero to two cycles and drops it at once. The bench drives requests only as one-cycle pulses on the falling edge. It also sends a deliberate request during a busy series, to confirm that such a request is ignored.

// File: rtl/tfence_pkg.sv
package tfence_pkg;

    typedef enum logic [1:0] {
        TM_NONE = 2'b00,
        TM_X    = 2'b01,
        TM_Y    = 2'b10,
        TM_RSVD = 2'b11
    } tmode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KILL,
        SQ_CHK1,
        SQ_HIGH,
        SQ_ARM,
        SQ_CHK2
    } sq_e;

endpackage

// File: rtl/tfence_encode.sv
module tfence_encode
    import tfence_pkg::*;
#(
    parameter int PITCH_SHIFT = 32,
    parameter int PITCH_W     = 10,
    parameter int Y_BIT       = 1,
    parameter int VALID_BIT   = 0
) (
    input  logic [31:0] start,
    input  logic [31:0] size,
    input  logic [31:0] stride,
    input  tmode_e      mode,
    input  logic        clear,
    output logic        ok,
    output logic [63:0] word
);
    localparam int UNIT_W = 25;
    localparam logic [32:0] PAGE = 33'h0_0000_1000;
    localparam logic [UNIT_W-1:0] UNIT_MAX = UNIT_W'(1) << PITCH_W;

    logic [32:0]        end_w;
    logic [UNIT_W-1:0]  units;
    logic [PITCH_W-1:0] pitch;
    logic [63:0]        pitch64;
    logic               align_ok, stride_ok, mode_ok, range_ok;

    always_comb begin
        units     = stride[31:7];
        pitch     = units[PITCH_W-1:0] - PITCH_W'(1);
        pitch64   = 64'(pitch) << PITCH_SHIFT;
        end_w     = {1'b0, start} + {1'b0, size} - PAGE;
        align_ok  = (start[11:0] == 12'd0) && (size[11:0] == 12'd0) && (size != 32'd0);
        stride_ok = (stride != 32'd0) && (stride[6:0] == 7'd0) && (units <= UNIT_MAX);
        mode_ok   = (mode == TM_X) || (mode == TM_Y);
        range_ok  = !end_w[32];
        ok        = clear || (align_ok && stride_ok && mode_ok && range_ok);
        word      = 64'd0;
        if (!clear) begin
            word = {end_w[31:12], 12'd0, start[31:12], 12'd0} | pitch64;
            word[VALID_BIT] = 1'b1;
            word[Y_BIT]     = (mode == TM_Y);
        end
    end

endmodule

// File: rtl/tfence_seq.sv
module tfence_seq
    import tfence_pkg::*;
#(
    parameter int          SLOT_W    = 5,
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0000_4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              reject,
    input  logic [SLOT_W-1:0] slot,
    input  logic [63:0]       word,
    input  logic              bus_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    output logic              busy,
    output logic              done,
    output logic              err
);
    typedef struct packed {
        sq_e               st;
        logic [63:0]       word;
        logic [ADDR_W-1:0] lo_addr;
        logic              done;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (go) begin
                    s_d.st      = SQ_KILL;
                    s_d.word    = word;
                    s_d.lo_addr = ADDR_W'(BASE_ADDR) + (ADDR_W'(slot) << 3);
                end else if (reject) begin
                    s_d.err = 1'b1;
                end
            end
            SQ_KILL: if (bus_ack) s_d.st = SQ_CHK1;
            SQ_CHK1: if (bus_ack) s_d.st = SQ_HIGH;
            SQ_HIGH: if (bus_ack) s_d.st = SQ_ARM;
            SQ_ARM:  if (bus_ack) s_d.st = SQ_CHK2;
            SQ_CHK2: begin
                if (bus_ack) begin
                    s_d.st   = SQ_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, word: 64'd0, lo_addr: '0, done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_req   = (s_q.st != SQ_IDLE);
        bus_we    = 1'b0;
        bus_addr  = s_q.lo_addr;
        bus_wdata = 32'd0;
        unique case (s_q.st)
            SQ_KILL: bus_we = 1'b1;
            SQ_HIGH: begin
                bus_we    = 1'b1;
                bus_addr  = s_q.lo_addr + ADDR_W'(4);
                bus_wdata = s_q.word[63:32];
            end
            SQ_ARM: begin
                bus_we    = 1'b1;
                bus_wdata = s_q.word[31:0];
            end
            default: ;
        endcase
        busy = bus_req;
        done = s_q.done;
        err  = s_q.err;
    end

    assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    assert_done_after_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_req) && $past(bus_ack) && !$past(bus_we)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!bus_req && !done));

endmodule

// File: rtl/tfence_prog.sv
module tfence_prog
    import tfence_pkg::*;
#(
    parameter int          SLOTS       = 32,
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] BASE_ADDR   = 32'h0000_4000,
    parameter int          PITCH_SHIFT = 32,
    parameter int          PITCH_W     = 10,
    parameter int          Y_BIT       = 1,
    parameter int          VALID_BIT   = 0,
    localparam int         SLOT_W      = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_clear,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [31:0]       req_start,
    input  logic [31:0]       req_size,
    input  logic [31:0]       req_stride,
    input  logic [1:0]        req_mode,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack
);
    logic        desc_ok;
    logic [63:0] desc_word;
    logic        take, go, reject;

    tfence_encode #(
        .PITCH_SHIFT(PITCH_SHIFT),
        .PITCH_W    (PITCH_W),
        .Y_BIT      (Y_BIT),
        .VALID_BIT  (VALID_BIT)
    ) u_enc (
        .start (req_start),
        .size  (req_size),
        .stride(req_stride),
        .mode  (tmode_e'(req_mode)),
        .clear (req_clear),
        .ok    (desc_ok),
        .word  (desc_word)
    );

    always_comb begin
        take   = req_valid && !busy;
        go     = take && desc_ok;
        reject = take && !desc_ok;
    end

    tfence_seq #(
        .SLOT_W   (SLOT_W),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .reject   (reject),
        .slot     (req_slot),
        .word     (desc_word),
        .bus_ack  (bus_ack),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .busy     (busy),
        .done     (done),
        .err      (err)
    );

    assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(req_valid) && !$past(busy)));

    assert_arm_is_last_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_ack && (bus_wdata[VALID_BIT] == 1'b1) && (bus_addr[2] == 1'b0))
        |=> (bus_req && !bus_we));

endmodule

// File: tb/tfence_prog_test.sv
module tfence_prog_test;
    localparam logic [31:0] BASE = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_clear = 1'b0;
    logic [4:0]  req_slot = '0;
    logic [31:0] req_start = '0, req_size = '0, req_stride = '0;
    logic [1:0]  req_mode = '0;
    logic        busy, done, err, bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack = 1'b0;

    int checks = 0, fails = 0;
    int cyc = 0;
    logic [31:0] mem [0:63];
    logic        lg_we [0:7];
    logic [31:0] lg_addr [0:7];
    logic [31:0] lg_data [0:7];
    int          lg_n = 0;
    int          last_ack_cyc = 0;
    int          wcnt = 0;
    bit          waiting = 0;
    logic [31:0] p_addr, p_data;
    logic        p_we;

    tfence_prog uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_clear(req_clear),
        .req_slot(req_slot), .req_start(req_start), .req_size(req_size),
        .req_stride(req_stride), .req_mode(req_mode), .busy(busy), .done(done),
        .err(err), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int idx(input logic [31:0] a);
        return int'((a - BASE) >> 2) & 63;
    endfunction

    // bus target model
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0; wcnt = 0; waiting = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (waiting)
                chk(bus_addr == p_addr && bus_we == p_we && bus_wdata == p_data,
                    "R10 held op", {bus_addr, bus_wdata}, {p_addr, p_data});
            if (wcnt > 0) begin
                p_addr = bus_addr; p_we = bus_we; p_data = bus_wdata;
                waiting = 1; wcnt--;
            end else begin
                waiting = 0;
                if (bus_we) mem[idx(bus_addr)] = bus_wdata;
                if (lg_n < 8) begin
                    lg_we[lg_n] = bus_we; lg_addr[lg_n] = bus_addr; lg_data[lg_n] = bus_wdata;
                end
                lg_n++;
                bus_ack = 1'b1;
                last_ack_cyc = cyc;
                wcnt = $urandom % 3;
            end
        end
    end

    function automatic logic [63:0] exp_word(input bit clr, input logic [31:0] st, input logic [31:0] sz,
                                             input logic [31:0] sd, input logic [1:0] md);
        logic [31:0] e, lo, hi;
        if (clr) return 64'd0;
        e  = st + sz - 32'h1000;
        lo = st | 32'h1 | ((md == 2'b10) ? 32'h2 : 32'h0);
        hi = {e[31:12], 12'd0} | ((sd >> 7) - 32'd1);
        return {hi, lo};
    endfunction

    task automatic do_req(input bit clr, input logic [4:0] sl, input logic [31:0] st, input logic [31:0] sz,
                          input logic [31:0] sd, input logic [1:0] md, input bit exp_ok, input bit poke_busy);
        logic [63:0] w;
        logic [31:0] lo_a, old_lo, old_hi, oth_lo;
        int          dc;
        w      = exp_word(clr, st, sz, sd, md);
        lo_a   = BASE + {24'd0, sl, 3'd0};
        old_lo = mem[idx(lo_a)];
        old_hi = mem[idx(lo_a + 4)];
        oth_lo = mem[idx(BASE + {24'd0, sl ^ 5'd1, 3'd0})];
        lg_n   = 0;
        @(negedge clk);
        req_valid = 1; req_clear = clr; req_slot = sl; req_start = st;
        req_size = sz; req_stride = sd; req_mode = md;
        @(negedge clk);
        req_valid = 0;
        if (!exp_ok) begin
            chk(err == 1'b1, "R7 err pulse", {63'd0, err}, 64'd1);
            repeat (3) @(negedge clk);
            chk(lg_n == 0 && !busy, "R7 no traffic", 64'(lg_n), 64'd0);
            chk(mem[idx(lo_a)] == old_lo && mem[idx(lo_a + 4)] == old_hi, "R7 slot kept",
                {mem[idx(lo_a + 4)], mem[idx(lo_a)]}, {old_hi, old_lo});
            return;
        end
        chk(busy == 1'b1 && err == 1'b0, "R8 busy after take", {62'd0, busy, err}, 64'd2);
        if (poke_busy) begin
            @(negedge clk);
            req_valid = 1; req_clear = 1; req_slot = sl ^ 5'd1;
            @(negedge clk);
            req_valid = 0;
        end
        dc = 0;
        for (int k = 0; k < 100 && !done; k++) @(negedge clk);
        dc = cyc;
        chk(done == 1'b1, "R9 done seen", {63'd0, done}, 64'd1);
        chk(dc == last_ack_cyc + 1 && !busy, "R9 done timing", 64'(dc), 64'(last_ack_cyc + 1));
        chk(lg_n == 5, "R4 op count", 64'(lg_n), 64'd5);
        if (lg_n == 5) begin
            chk({lg_we[0], lg_we[1], lg_we[2], lg_we[3], lg_we[4]} == 5'b10110, "R4 op kinds",
                {59'd0, lg_we[0], lg_we[1], lg_we[2], lg_we[3], lg_we[4]}, 64'b10110);
            chk(lg_data[0] == 32'd0, "R4 disable first", 64'(lg_data[0]), 64'd0);
            chk(lg_data[2] == w[63:32] && lg_data[3] == w[31:0], "R4 halves order",
                {lg_data[2], lg_data[3]}, w);
            chk(lg_addr[0] == lo_a && lg_addr[1] == lo_a && lg_addr[2] == lo_a + 4 &&
                lg_addr[3] == lo_a && lg_addr[4] == lo_a, "R5 addresses",
                {lg_addr[2], lg_addr[3]}, {lo_a + 32'd4, lo_a});
        end
        if (clr)
            chk(mem[idx(lo_a)] == 0 && mem[idx(lo_a + 4)] == 0, "R6 cleared",
                {mem[idx(lo_a + 4)], mem[idx(lo_a)]}, 64'd0);
        else begin
            chk(mem[idx(lo_a)] == w[31:0] && mem[idx(lo_a + 4)][31:12] == w[63:44], "R2 word",
                {mem[idx(lo_a + 4)], mem[idx(lo_a)]}, w);
            chk(mem[idx(lo_a + 4)][9:0] == w[41:32], "R3 pitch",
                64'(mem[idx(lo_a + 4)][9:0]), 64'(w[41:32]));
        end
        @(negedge clk);
        @(negedge clk);
        chk(lg_n == 5 && !busy, "R8 no extra traffic", 64'(lg_n), 64'd5);
        if (poke_busy)
            chk(mem[idx(BASE + {24'd0, sl ^ 5'd1, 3'd0})] == oth_lo, "R8 busy request ignored",
                64'(mem[idx(BASE + {24'd0, sl ^ 5'd1, 3'd0})]), 64'(oth_lo));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hA5A5_0000 | i;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !bus_req, "R1 in reset", {60'd0, busy, done, err, bus_req}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !err && !bus_req, "R1 after reset", {60'd0, busy, done, err, bus_req}, 64'd0);

        // directed corners
        do_req(0, 5'd0,  32'h0010_0000, 32'h0000_1000, 32'd128,        2'b01, 1, 0);
        do_req(0, 5'd31, 32'hFFFF_F000, 32'h0000_1000, 32'd131072,     2'b10, 1, 0);
        do_req(0, 5'd7,  32'h0020_0000, 32'h0004_0000, 32'd512,        2'b10, 1, 1);
        do_req(1, 5'd31, 32'h1234_5678, 32'h0,         32'd0,          2'b00, 1, 0);
        do_req(0, 5'd3,  32'h0010_0800, 32'h0000_1000, 32'd128,        2'b01, 0, 0);
        do_req(0, 5'd3,  32'h0010_0000, 32'h0000_0000, 32'd128,        2'b01, 0, 0);
        do_req(0, 5'd3,  32'h0010_0000, 32'h0000_1800, 32'd128,        2'b01, 0, 0);
        do_req(0, 5'd3,  32'h0010_0000, 32'h0000_1000, 32'd0,          2'b01, 0, 0);
        do_req(0, 5'd3,  32'h0010_0000, 32'h0000_1000, 32'd200,        2'b01, 0, 0);
        do_req(0, 5'd3,  32'h0010_0000, 32'h0000_1000, 32'd128,        2'b00, 0, 0);
        do_req(0, 5'd3,  32'h0010_0000, 32'h0000_1000, 32'd128,        2'b11, 0, 0);
        do_req(0, 5'd3,  32'h0010_0000, 32'h0000_1000, 32'd131200,     2'b01, 0, 0);
        do_req(0, 5'd3,  32'hFFFF_0000, 32'h0002_0000, 32'd128,        2'b01, 0, 0);

        // random region and clear requests
        for (int n = 0; n < 60; n++) begin
            logic [31:0] st, sz, sd;
            logic [1:0]  md;
            st = {1'b0, 19'($urandom), 12'd0};
            sz = ((($urandom % 64) + 1) << 12);
            sd = ((($urandom % 1024) + 1) << 7);
            md = ($urandom % 2) ? 2'b01 : 2'b10;
            do_req(($urandom % 6) == 0, 5'($urandom), st, sz, sd, md, 1, ($urandom % 5) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule